// File: doc/BRIEF.md
# Translation Unit Control and Fault Reporting Block

This block is the software-facing control and fault-status register set for a device-side address translation unit. A mode register puts the unit into one of three states: off, translating, or stalled. Eight kinds of fault arrive as single-cycle pulses with a shared address. Each pulse sets a status bit and raises the interrupt. It also loads the fault address into one of four capture registers, chosen by the fault's class. Every accepted fault puts the unit into the stalled state at once.

Software reads the status register, or the lowest-pending index, to find which fault to handle first. It clears faults by writing ones to the clear register. It then writes the translating code to resume. A resume request is refused while any fault is still pending. Writing the flush register, or loading a new table base, emits a one-cycle TLB invalidate strobe. A configuration bit selects the small first-level table format.

All writes are registered. Reads are combinational from `addr_i`.

Top module: `mmu_ctl_top`

## Requirements
- R1: After reset the mode register (offset 0x00) reads 0, status reads 0, and all captured addresses, the table base and the config register read 0. `irq_o`, `enabled_o`, `blocked_o`, `flush_o` and `small_tbl_o` are all low.
- R2: Mode codes, written as the full 32-bit word to offset 0x00, are 0x0 for off, 0x5 for translating (`enabled_o` high) and 0x7 for stalled (`blocked_o` high). Any other written value leaves the mode unchanged.
- R3: The status register at 0x10 holds one bit per fault type: bit 0 page fault, bit 1 read multi-hit, bit 2 write multi-hit, bit 3 bus error, bit 4 read security, bit 5 read access, bit 6 write security, bit 7 write access. `irq_o` is the OR of these bits.
- R4: A fault accepted while the mode is translating or stalled sets the mode to stalled (0x7) at the same clock edge that sets its status bit. This takes priority over a mode write in that cycle.
- R5: The fault address is captured by class. Type 0 goes to offset 0x1C. Types 1, 4 and 5 go to 0x20. Types 2, 6 and 7 go to 0x24. Type 3 goes to 0x28.
- R6: A fault whose status bit is already set does not change the captured address.
- R7: Writing to offset 0x14 clears every status bit written as one. A fault arriving in the same cycle as the clear of its own bit leaves that bit set.
- R8: A write of 0x5 to the mode register is refused while any status bit is set. Once status is zero, the same write is accepted.
- R9: While the mode is off, fault pulses set no status bit and capture no address.
- R10: Offset 0x18 reads, in bits [2:0], the index of the lowest set status bit. It reads 0 when status is zero.
- R11: A write to offset 0x08 with bit 0 set produces a single-cycle `flush_o` pulse in the cycle after the write. A write with bit 0 clear produces no pulse.
- R12: A write to offset 0x0C stores the table base, which reads back there and drives `tbase_o`. The write also produces the same single-cycle `flush_o` pulse.
- R13: The config register at offset 0x04 keeps only bit 5, which drives `small_tbl_o` (1 selects the small first-level table). Reads return only that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| fault_i | input | 8 | Fault pulses, one bit per fault type |
| fault_addr_i | input | 32 | Address associated with the fault pulses |
| irq_o | output | 1 | Fault interrupt |
| enabled_o | output | 1 | Mode is translating |
| blocked_o | output | 1 | Mode is stalled |
| flush_o | output | 1 | One-cycle TLB invalidate strobe |
| small_tbl_o | output | 1 | Small first-level table selected |
| tbase_o | output | 32 | Table base address |

## Verification
The bench sends a repeat fault into a pending type and checks that the captured address does not move. A design that overwrote it would point software at the later address. It raises a fault and its clear in the same cycle. A design where the clear won would silently drop that fault. It asks for a resume while faults are pending and expects the unit to stay stalled, where a faulty design would resume translation over an unhandled fault. It also fires all eight faults while the unit is off, checks the routing of read, write and bus faults to separate capture registers, and checks the lowest-first index after part of the status has been cleared.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;
  localparam int unsigned NUM_FAULTS = 8;
  localparam int unsigned NUM_CLASS  = 4;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned OFS_W      = 8;

  localparam logic [DATA_W-1:0] MODE_OFF = 32'h0;
  localparam logic [DATA_W-1:0] MODE_RUN = 32'h5;
  localparam logic [DATA_W-1:0] MODE_STL = 32'h7;

  localparam logic [OFS_W-1:0] OFS_MODE  = 8'h00;
  localparam logic [OFS_W-1:0] OFS_CFG   = 8'h04;
  localparam logic [OFS_W-1:0] OFS_FLUSH = 8'h08;
  localparam logic [OFS_W-1:0] OFS_TBASE = 8'h0C;
  localparam logic [OFS_W-1:0] OFS_STAT  = 8'h10;
  localparam logic [OFS_W-1:0] OFS_CLR   = 8'h14;
  localparam logic [OFS_W-1:0] OFS_PRIO  = 8'h18;
  localparam logic [OFS_W-1:0] OFS_CAP0  = 8'h1C;

  localparam int unsigned CFG_SMALL_BIT = 5;

  typedef enum logic [1:0] {CL_PAGE = 2'd0, CL_READ = 2'd1, CL_WRITE = 2'd2, CL_BUS = 2'd3} fclass_e;

  function automatic fclass_e class_of(input int unsigned idx);
    case (idx)
      0:       return CL_PAGE;
      3:       return CL_BUS;
      1, 4, 5: return CL_READ;
      default: return CL_WRITE;
    endcase
  endfunction
endpackage

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture
  import mmu_ctl_pkg::*;
#(
  parameter int unsigned NF = NUM_FAULTS,
  parameter int unsigned AW = DATA_W,
  localparam int unsigned IW = $clog2(NF)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          accept_en_i,
  input  logic [NF-1:0]                 fault_i,
  input  logic [AW-1:0]                 fault_addr_i,
  input  logic [NF-1:0]                 clr_i,
  output logic [NF-1:0]                 status_o,
  output logic [IW-1:0]                 prio_o,
  output logic [NUM_CLASS-1:0][AW-1:0]  cap_o
);
  logic [NF-1:0] acc, fresh;
  assign acc   = accept_en_i ? fault_i : '0;
  assign fresh = acc & ~status_o;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) status_o <= '0;
    else         status_o <= (status_o & ~clr_i) | acc;  // new fault beats clear

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
    logic [NF-1:0] cmask;
    always_comb
      for (int i = 0; i < NF; i++) cmask[i] = (class_of(i) == fclass_e'(c));

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                cap_o[c] <= '0;
      else if (|(fresh & cmask))  cap_o[c] <= fault_addr_i;
  end

  always_comb begin
    prio_o = '0;
    for (int i = NF - 1; i >= 0; i--)
      if (status_o[i]) prio_o = IW'(i);
  end

  p_quiet_when_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(accept_en_i) |-> ((status_o & ~$past(status_o)) == '0));
  p_hold_page_addr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(status_o[0]) |-> $stable(cap_o[0]));
  p_hold_bus_addr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(status_o[3]) |-> $stable(cap_o[3]));
endmodule

// File: rtl/mmu_ctrl_regs.sv
module mmu_ctrl_regs
  import mmu_ctl_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned OW = OFS_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [OW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          fault_hit_i,
  input  logic          pending_i,
  output logic [DW-1:0] mode_o,
  output logic          small_o,
  output logic [DW-1:0] tbase_o,
  output logic          flush_o
);
  logic wr_mode, wr_cfg, wr_tb, wr_fl, legal;
  assign wr_mode = wr_en_i && addr_i == OW'(OFS_MODE);
  assign wr_cfg  = wr_en_i && addr_i == OW'(OFS_CFG);
  assign wr_tb   = wr_en_i && addr_i == OW'(OFS_TBASE);
  assign wr_fl   = wr_en_i && addr_i == OW'(OFS_FLUSH);
  assign legal   = wdata_i == MODE_OFF || wdata_i == MODE_STL ||
                   (wdata_i == MODE_RUN && !pending_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      mode_o  <= MODE_OFF;
      small_o <= 1'b0;
      tbase_o <= '0;
      flush_o <= 1'b0;
    end else begin
      if (fault_hit_i)            mode_o <= MODE_STL;
      else if (wr_mode && legal)  mode_o <= wdata_i;
      if (wr_cfg) small_o <= wdata_i[CFG_SMALL_BIT];
      if (wr_tb)  tbase_o <= wdata_i;
      flush_o <= wr_tb || (wr_fl && wdata_i[0]);  // new base always invalidates
    end

  p_fault_stalls_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fault_hit_i) |-> mode_o == MODE_STL);
  p_mode_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == MODE_OFF || mode_o == MODE_RUN || mode_o == MODE_STL);
endmodule

// File: rtl/mmu_ctl_top.sv
module mmu_ctl_top
  import mmu_ctl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic [7:0]  fault_i,
  input  logic [31:0] fault_addr_i,
  output logic        irq_o,
  output logic        enabled_o,
  output logic        blocked_o,
  output logic        flush_o,
  output logic        small_tbl_o,
  output logic [31:0] tbase_o
);
  localparam int unsigned IW = $clog2(NUM_FAULTS);

  logic [DATA_W-1:0]                   mode;
  logic [NUM_FAULTS-1:0]               status, clr;
  logic [IW-1:0]                       prio;
  logic [NUM_CLASS-1:0][DATA_W-1:0]    cap;
  logic                                active;

  assign active = mode != MODE_OFF;
  assign clr    = (wr_en_i && addr_i == OFS_CLR) ? wdata_i[NUM_FAULTS-1:0] : '0;

  mmu_fault_capture u_cap (
    .clk_i, .rst_ni,
    .accept_en_i  (active),
    .fault_i,
    .fault_addr_i,
    .clr_i        (clr),
    .status_o     (status),
    .prio_o       (prio),
    .cap_o        (cap)
  );

  mmu_ctrl_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .fault_hit_i (active && |fault_i),
    .pending_i   (|status),
    .mode_o      (mode),
    .small_o     (small_tbl_o),
    .tbase_o,
    .flush_o
  );

  assign irq_o     = |status;
  assign enabled_o = mode == MODE_RUN;
  assign blocked_o = mode == MODE_STL;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_MODE:  rdata_o = mode;
      OFS_CFG:   rdata_o[CFG_SMALL_BIT] = small_tbl_o;
      OFS_TBASE: rdata_o = tbase_o;
      OFS_STAT:  rdata_o[NUM_FAULTS-1:0] = status;
      OFS_PRIO:  rdata_o[IW-1:0] = prio;
      default:
        for (int c = 0; c < NUM_CLASS; c++)
          if (addr_i == OFS_CAP0 + 8'(4 * c)) rdata_o = cap[c];
    endcase
  end

  p_run_clean_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enabled_o |-> !irq_o);
  p_irq_stalls_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !$past(irq_o)) |-> blocked_o);
  p_flush_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(wr_en_i && ((addr_i == OFS_FLUSH && wdata_i[0]) || addr_i == OFS_TBASE)));
endmodule

// File: tb/sim_mmu_ctl_top.sv
module sim_mmu_ctl_top;
  logic        clk_i = 1'b0, rst_ni = 1'b0, wr_en_i = 1'b0;
  logic [7:0]  addr_i = '0, fault_i = '0;
  logic [31:0] wdata_i = '0, fault_addr_i = '0, rdata_o, tbase_o;
  logic        irq_o, enabled_o, blocked_o, flush_o, small_tbl_o;

  always #10 clk_i = ~clk_i;  // 50 MHz

  mmu_ctl_top u0 (.*);

  typedef struct { string tag; bit pins; logic [31:0] exp; } item_t;
  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // monitor: compare one expected item per cycle, away from the clock edge
  always @(negedge clk_i) begin
    if (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = it.pins ? {27'b0, irq_o, enabled_o, blocked_o, flush_o, small_tbl_o} : rdata_o;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step(); @(posedge clk_i); #1; endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d; step(); wr_en_i = 1'b0;
  endtask

  task automatic flt(input logic [7:0] m, input logic [31:0] a);
    fault_i = m; fault_addr_i = a; step(); fault_i = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    addr_i = a; q.push_back('{tag, 1'b0, e}); step();
  endtask

  // pins = {irq, enabled, blocked, flush, small}
  task automatic pins(input logic [4:0] e, input string tag);
    q.push_back('{tag, 1'b1, {27'b0, e}}); step();
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    step();
    pins(5'b00000, "R1 pins after reset");
    rd(8'h00, 0, "R1 mode");
    rd(8'h10, 0, "R1 status");
    rd(8'h1C, 0, "R1 page addr");

    wr(8'h00, 32'h5);        pins(5'b01000, "R2 run");
    wr(8'h00, 32'h3);        rd(8'h00, 32'h5, "R2 illegal code ignored");

    flt(8'h01, 32'h1000);    pins(5'b10100, "R4 fault stalls");
    rd(8'h10, 32'h01, "R3 status bit0");
    rd(8'h1C, 32'h1000, "R5 page addr");
    flt(8'h01, 32'h2000);    rd(8'h1C, 32'h1000, "R6 no overwrite");
    flt(8'h10, 32'h4444);
    flt(8'h40, 32'h6666);
    flt(8'h08, 32'h3333);
    rd(8'h20, 32'h4444, "R5 read class");
    rd(8'h24, 32'h6666, "R5 write class");
    rd(8'h28, 32'h3333, "R5 bus class");
    rd(8'h10, 32'h59, "R3 status mix");
    rd(8'h18, 0, "R10 prio lowest 0");

    wr(8'h00, 32'h5);        rd(8'h00, 32'h7, "R8 resume refused");
    wr(8'h14, 32'h01);       rd(8'h18, 3, "R10 prio after clear");
    rd(8'h10, 32'h58, "R7 partial clear");
    wr(8'h14, 32'h58);       pins(5'b00100, "R7 all cleared irq low");
    wr(8'h00, 32'h5);        rd(8'h00, 32'h5, "R8 resume accepted");

    // fault and clear of the same bit in one cycle
    fault_i = 8'h02; fault_addr_i = 32'h1111;
    wr(8'h14, 32'h02); fault_i = '0;
    rd(8'h10, 32'h02, "R7 set beats clear");
    rd(8'h20, 32'h1111, "R5 read class recapture");
    wr(8'h14, 32'h02);
    wr(8'h00, 32'h0);        pins(5'b00000, "R2 off");
    flt(8'hFF, 32'h9999);    rd(8'h10, 0, "R9 off ignores faults");
    rd(8'h1C, 32'h1000, "R9 no capture when off");

    wr(8'h08, 32'h1);        pins(5'b00010, "R11 flush pulse");
    pins(5'b00000, "R11 flush single cycle");
    wr(8'h08, 32'h0);        pins(5'b00000, "R11 no pulse bit0 clear");

    wr(8'h0C, 32'hABCD0000); pins(5'b00010, "R12 base write flushes");
    rd(8'h0C, 32'hABCD0000, "R12 base readback");
    if (tbase_o !== 32'hABCD0000) begin
      n_fail++; $display("FAIL R12 tbase_o actual=%h expected=%h", tbase_o, 32'hABCD0000);
    end
    n_chk++;

    wr(8'h04, 32'h20);       pins(5'b00001, "R13 small table");
    rd(8'h04, 32'h20, "R13 cfg readback");
    wr(8'h04, 32'hFFFFFFDF); rd(8'h04, 0, "R13 only bit5 kept");

    step(); step();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule